// File: doc/BRIEF.md
# Two-Level Table Entry Address Walker

This block turns an entry index into the system-memory address of that entry. The table it addresses is either a single contiguous array (flat mode) or a two-level structure. In the two-level structure a first-level array of 8-byte descriptors points at second-level pages that hold the entries. The walker serves two kinds of request: a lookup, which reads the 64-bit entry and returns it, and an update, which writes a new 64-bit entry. It reaches memory through a master port that has a single outstanding transaction, a valid/ready request channel and a separate response channel that carries an error flag.

In two-level mode the walker first fetches the descriptor that covers the index and tests its valid bit. Only then does it form the entry address inside the second-level page. A memory error stops the walk and reports a fault, which the caller treats as a stall. A descriptor with its valid bit clear means that no page backs that range of indices. A lookup then returns an all-zero entry, and an update is dropped. Neither case is an error. Page and entry sizes are powers of two and are configured as log2 values, so every division and modulo becomes a shift or a mask.

A request is taken only while the walker is idle. The outcome is announced by a one-cycle done pulse. The outcome is a status code, plus the entry data for a lookup, and it stays on the outputs until the next request is accepted.

Top module: `entry_walker`

## Requirements
- R1: After reset, req_ready is 1, done is 0, mem_req_valid is 0, rsp_status is 0 and rsp_rdata is 0.
- R2: With cfg_two_level at 0, the entry address is cfg_base + index * 2^cfg_entry_lg2. The request makes exactly one memory transaction and fetches no descriptor.
- R3: With cfg_two_level at 1, a descriptor is first read from cfg_base + 8 * (index / (2^cfg_page_lg2 / 8)). The entry is then accessed at descriptor bits [50:0] + (index mod (2^cfg_page_lg2 / 2^cfg_entry_lg2)) * 2^cfg_entry_lg2. Descriptor bits 62..51 play no part in the address.
- R4: A descriptor is valid only when its bit 63 is 1. For a lookup whose descriptor has bit 63 at 0, the walker finishes after that one read, with rsp_status 2 (not mapped, not an error) and rsp_rdata all zero.
- R5: For an update whose descriptor has bit 63 at 0, no memory write is issued and the walker finishes with rsp_status 2.
- R6: A memory error on the descriptor read ends the request with rsp_status 1 (fault) and rsp_rdata zero. No further memory transaction follows.
- R7: An update with a valid path writes req_wdata as one 64-bit little-endian word, with byte 0 on bits 7:0. rsp_status is 0 only if that write's response carries no error, and 1 otherwise.
- R8: A lookup with a valid path returns the 64-bit word read at the entry address with rsp_status 0. If that read returns an error, rsp_status is 1 and rsp_rdata is zero.
- R9: req_ready is 1 only while idle, so no request is taken during a walk. done is high for exactly one cycle per request. rsp_status and rsp_rdata change only in the done cycle and hold until the next completion.
- R10: While mem_req_valid is 1 and mem_req_ready is 0, the request and its address, data and write flag hold steady. At most one memory transaction is outstanding, and a lookup issues no memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_two_level | input | 1 | 1 selects the two-level table, 0 the flat table |
| cfg_base | input | ADDR_W | Table base address (flat array or first-level array) |
| cfg_page_lg2 | input | LG_W | log2 of the second-level page size in bytes (at least 3) |
| cfg_entry_lg2 | input | LG_W | log2 of the entry size in bytes (not above cfg_page_lg2) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_write | input | 1 | 1 for update, 0 for lookup |
| req_index | input | IDX_W | Entry index |
| req_wdata | input | 64 | New entry for an update |
| done | output | 1 | One-cycle completion pulse |
| rsp_status | output | 2 | 0 ok, 1 fault, 2 not mapped |
| rsp_rdata | output | 64 | Entry read by the last lookup, zero otherwise |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | Memory request is a write |
| mem_req_addr | output | ADDR_W | Memory byte address |
| mem_req_wdata | output | 64 | Memory write data |
| mem_rsp_valid | input | 1 | Memory response valid |
| mem_rsp_err | input | 1 | Memory response carries an error |
| mem_rsp_rdata | input | 64 | Memory read data |

## Verification
Flat lookups and updates with two entry sizes show that the flat path uses the entry-size shift and never fetches a descriptor. Two-level walks with two page/entry size pairs tell the slot divide apart from the in-page modulo. A descriptor with junk in bits 62..51 shows that only the 51-bit pointer forms the address. Descriptors with bit 63 clear, together with errors injected at the descriptor, entry-read and entry-write addresses, separate the not-mapped outcome from the fault outcome for both request kinds. A walk under a toggling mem_req_ready shows that the result does not depend on memory backpressure.

// File: rtl/entry_walker_pkg.sv
package entry_walker_pkg;

   localparam int unsigned WORD_W        = 64;
   localparam int unsigned DESC_BYTES_LG2 = 3;

   typedef enum logic [1:0] {
      ST_OK    = 2'd0,
      ST_FAULT = 2'd1,
      ST_NOMAP = 2'd2
   } ew_status_e;

   typedef enum logic [1:0] {
      W_IDLE = 2'd0,
      W_L1   = 2'd1,
      W_ENT  = 2'd2
   } ew_walk_e;

   typedef enum logic [1:0] {
      P_IDLE = 2'd0,
      P_REQ  = 2'd1,
      P_WAIT = 2'd2
   } ew_port_e;

endpackage

// File: rtl/ew_addr_calc.sv
module ew_addr_calc
   import entry_walker_pkg::*;
#(
   parameter int unsigned ADDR_W       = 52,
   parameter int unsigned IDX_W        = 20,
   parameter int unsigned LG_W         = 5,
   parameter int unsigned PTR_W        = 51,
   parameter bit          TWO_LEVEL_EN = 1'b1
) (
   input  logic [ADDR_W-1:0] cfg_base,
   input  logic [LG_W-1:0]   cfg_page_lg2,
   input  logic [LG_W-1:0]   cfg_entry_lg2,
   input  logic [IDX_W-1:0]  idx_i,
   input  logic [PTR_W-1:0]  desc_ptr_i,
   output logic [ADDR_W-1:0] flat_addr_o,
   output logic [ADDR_W-1:0] l1_addr_o,
   output logic [ADDR_W-1:0] l2_addr_o
);

   // flat array: base plus scaled index
   assign flat_addr_o = cfg_base + (ADDR_W'(idx_i) << cfg_entry_lg2);

   if (TWO_LEVEL_EN) begin : g_two_level
      logic [LG_W-1:0]  slot_shift;
      logic [LG_W-1:0]  per_page_lg2;
      logic [IDX_W-1:0] slot_num;
      logic [IDX_W-1:0] in_page;

      // descriptors per page = 2^(page_lg2 - 3), entries per page = 2^(page_lg2 - entry_lg2)
      assign slot_shift   = cfg_page_lg2 - LG_W'(DESC_BYTES_LG2);
      assign per_page_lg2 = cfg_page_lg2 - cfg_entry_lg2;
      assign slot_num     = idx_i >> slot_shift;
      assign in_page      = idx_i & ~({IDX_W{1'b1}} << per_page_lg2);
      assign l1_addr_o    = cfg_base + (ADDR_W'(slot_num) << DESC_BYTES_LG2);
      assign l2_addr_o    = ADDR_W'(desc_ptr_i) + (ADDR_W'(in_page) << cfg_entry_lg2);
   end else begin : g_flat_only
      logic unused_two;
      assign unused_two = ^{cfg_page_lg2, desc_ptr_i};
      assign l1_addr_o  = '0;
      assign l2_addr_o  = '0;
   end

endmodule

// File: rtl/ew_mem_port.sv
module ew_mem_port
   import entry_walker_pkg::*;
#(
   parameter int unsigned ADDR_W = 52
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [WORD_W-1:0] wdata_i,
   output logic              fin_o,
   output logic              err_o,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic              mem_req_write,
   output logic [ADDR_W-1:0] mem_req_addr,
   output logic [WORD_W-1:0] mem_req_wdata,
   input  logic              mem_rsp_valid,
   input  logic              mem_rsp_err
);

   ew_port_e          ph_q;
   logic              wr_q;
   logic [ADDR_W-1:0] addr_q;
   logic [WORD_W-1:0] wdata_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q    <= P_IDLE;
         wr_q    <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
      end else if (start_i) begin
         ph_q    <= P_REQ;
         wr_q    <= wr_i;
         addr_q  <= addr_i;
         wdata_q <= wdata_i;
      end else begin
         unique case (ph_q)
            P_REQ:   if (mem_req_ready) ph_q <= P_WAIT;
            P_WAIT:  if (mem_rsp_valid) ph_q <= P_IDLE;
            default: ph_q <= P_IDLE;
         endcase
      end
   end

   assign mem_req_valid = (ph_q == P_REQ);
   assign mem_req_write = wr_q;
   assign mem_req_addr  = addr_q;
   assign mem_req_wdata = wdata_q;
   assign fin_o         = (ph_q == P_WAIT) && mem_rsp_valid;
   assign err_o         = mem_rsp_err;

   // R10: request fields hold while stalled
   a_r10_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=>
         mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_wdata) && $stable(mem_req_write));

   // R10: a new transaction only starts when the previous one is finished
   a_r10_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |-> (ph_q == P_IDLE) || fin_o);

endmodule

// File: rtl/ew_ctrl.sv
module ew_ctrl
   import entry_walker_pkg::*;
#(
   parameter int unsigned ADDR_W       = 52,
   parameter int unsigned IDX_W        = 20,
   parameter int unsigned VALID_BIT    = 63,
   parameter bit          TWO_LEVEL_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_two_level,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [IDX_W-1:0]  req_index,
   input  logic [WORD_W-1:0] req_wdata,
   output logic [IDX_W-1:0]  idx_o,
   input  logic [ADDR_W-1:0] flat_addr_i,
   input  logic [ADDR_W-1:0] l1_addr_i,
   input  logic [ADDR_W-1:0] l2_addr_i,
   output logic              port_start,
   output logic              port_wr,
   output logic [ADDR_W-1:0] port_addr,
   output logic [WORD_W-1:0] port_wdata,
   input  logic              port_fin,
   input  logic              port_err,
   input  logic [WORD_W-1:0] port_rdata,
   output logic              done_o,
   output logic [1:0]        status_o,
   output logic [WORD_W-1:0] rdata_o
);

   ew_walk_e          st_q, st_d;
   logic              wr_q;
   logic [IDX_W-1:0]  idx_q;
   logic [WORD_W-1:0] wdata_q;
   logic              done_q;
   ew_status_e        status_q;
   logic [WORD_W-1:0] rdata_q;

   logic              two_lvl;
   logic              accept;
   logic              fin_now;
   ew_status_e        fin_status;
   logic [WORD_W-1:0] fin_data;

   assign two_lvl   = TWO_LEVEL_EN && cfg_two_level;
   assign req_ready = (st_q == W_IDLE);
   assign accept    = req_ready && req_valid;
   assign idx_o     = req_ready ? req_index : idx_q;

   always_comb begin
      st_d       = st_q;
      port_start = 1'b0;
      port_wr    = 1'b0;
      port_addr  = flat_addr_i;
      port_wdata = wdata_q;
      fin_now    = 1'b0;
      fin_status = ST_OK;
      fin_data   = '0;
      unique case (st_q)
         W_IDLE: begin
            if (req_valid) begin
               port_start = 1'b1;
               port_wr    = req_write && !two_lvl;
               port_addr  = two_lvl ? l1_addr_i : flat_addr_i;
               port_wdata = req_wdata;
               st_d       = two_lvl ? W_L1 : W_ENT;
            end
         end
         W_L1: begin
            if (port_fin) begin
               if (port_err) begin
                  fin_now    = 1'b1;
                  fin_status = ST_FAULT;
               end else if (!port_rdata[VALID_BIT]) begin
                  fin_now    = 1'b1;
                  fin_status = ST_NOMAP;
               end else begin
                  port_start = 1'b1;
                  port_wr    = wr_q;
                  port_addr  = l2_addr_i;
                  st_d       = W_ENT;
               end
            end
         end
         W_ENT: begin
            if (port_fin) begin
               fin_now    = 1'b1;
               fin_status = port_err ? ST_FAULT : ST_OK;
               fin_data   = (!wr_q && !port_err) ? port_rdata : '0;
            end
         end
         default: st_d = W_IDLE;
      endcase
      if (fin_now) st_d = W_IDLE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= W_IDLE;
         wr_q     <= 1'b0;
         idx_q    <= '0;
         wdata_q  <= '0;
         done_q   <= 1'b0;
         status_q <= ST_OK;
         rdata_q  <= '0;
      end else begin
         st_q   <= st_d;
         done_q <= fin_now;
         if (accept) begin
            wr_q    <= req_write;
            idx_q   <= req_index;
            wdata_q <= req_wdata;
         end
         if (fin_now) begin
            status_q <= fin_status;
            rdata_q  <= fin_data;
         end
      end
   end

   assign done_o   = done_q;
   assign status_o = status_q;
   assign rdata_o  = rdata_q;

   // R9: completion is a single-cycle pulse
   a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

   // R9: result only moves in the done cycle
   a_r9_result_held: assert property (@(posedge clk) disable iff (!rst_n)
      !done_q |-> $stable(status_q) && $stable(rdata_q));

   // R4: an unmapped outcome never carries entry data
   a_r4_nomap_zero: assert property (@(posedge clk) disable iff (!rst_n)
      done_q && (status_q == ST_NOMAP) |-> rdata_q == '0);

   // R6: a fault never carries entry data
   a_r6_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
      done_q && (status_q == ST_FAULT) |-> rdata_q == '0);

   // R7: memory writes are only issued on behalf of updates
   a_r7_write_only_update: assert property (@(posedge clk) disable iff (!rst_n)
      port_start && port_wr && (st_q != W_IDLE) |-> wr_q);

endmodule

// File: rtl/entry_walker.sv
module entry_walker
   import entry_walker_pkg::*;
#(
   parameter int unsigned ADDR_W       = 52,
   parameter int unsigned IDX_W        = 20,
   parameter int unsigned LG_W         = 5,
   parameter int unsigned PTR_W        = 51,
   parameter int unsigned VALID_BIT    = 63,
   parameter bit          TWO_LEVEL_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_two_level,
   input  logic [ADDR_W-1:0] cfg_base,
   input  logic [LG_W-1:0]   cfg_page_lg2,
   input  logic [LG_W-1:0]   cfg_entry_lg2,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [IDX_W-1:0]  req_index,
   input  logic [63:0]       req_wdata,
   output logic              done,
   output logic [1:0]        rsp_status,
   output logic [63:0]       rsp_rdata,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic              mem_req_write,
   output logic [ADDR_W-1:0] mem_req_addr,
   output logic [63:0]       mem_req_wdata,
   input  logic              mem_rsp_valid,
   input  logic              mem_rsp_err,
   input  logic [63:0]       mem_rsp_rdata
);

   if (ADDR_W < PTR_W) begin : g_chk_addr
      $error("entry_walker: ADDR_W must cover the descriptor pointer");
   end
   if (IDX_W < 1 || IDX_W > 32) begin : g_chk_idx
      $error("entry_walker: IDX_W out of range");
   end
   if (LG_W < 3 || LG_W > 6) begin : g_chk_lg
      $error("entry_walker: LG_W out of range");
   end
   if (VALID_BIT < PTR_W || VALID_BIT >= WORD_W) begin : g_chk_valid
      $error("entry_walker: VALID_BIT overlaps pointer or word");
   end

   logic [IDX_W-1:0]  idx_sel;
   logic [ADDR_W-1:0] flat_addr, l1_addr, l2_addr;
   logic              p_start, p_wr, p_fin, p_err;
   logic [ADDR_W-1:0] p_addr;
   logic [WORD_W-1:0] p_wdata;

   ew_addr_calc #(
      .ADDR_W(ADDR_W), .IDX_W(IDX_W), .LG_W(LG_W), .PTR_W(PTR_W), .TWO_LEVEL_EN(TWO_LEVEL_EN)
   ) u_calc (
      .cfg_base      (cfg_base),
      .cfg_page_lg2  (cfg_page_lg2),
      .cfg_entry_lg2 (cfg_entry_lg2),
      .idx_i         (idx_sel),
      .desc_ptr_i    (mem_rsp_rdata[PTR_W-1:0]),
      .flat_addr_o   (flat_addr),
      .l1_addr_o     (l1_addr),
      .l2_addr_o     (l2_addr)
   );

   ew_ctrl #(
      .ADDR_W(ADDR_W), .IDX_W(IDX_W), .VALID_BIT(VALID_BIT), .TWO_LEVEL_EN(TWO_LEVEL_EN)
   ) u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .cfg_two_level (cfg_two_level),
      .req_valid     (req_valid),
      .req_ready     (req_ready),
      .req_write     (req_write),
      .req_index     (req_index),
      .req_wdata     (req_wdata),
      .idx_o         (idx_sel),
      .flat_addr_i   (flat_addr),
      .l1_addr_i     (l1_addr),
      .l2_addr_i     (l2_addr),
      .port_start    (p_start),
      .port_wr       (p_wr),
      .port_addr     (p_addr),
      .port_wdata    (p_wdata),
      .port_fin      (p_fin),
      .port_err      (p_err),
      .port_rdata    (mem_rsp_rdata),
      .done_o        (done),
      .status_o      (rsp_status),
      .rdata_o       (rsp_rdata)
   );

   ew_mem_port #(.ADDR_W(ADDR_W)) u_port (
      .clk           (clk),
      .rst_n         (rst_n),
      .start_i       (p_start),
      .wr_i          (p_wr),
      .addr_i        (p_addr),
      .wdata_i       (p_wdata),
      .fin_o         (p_fin),
      .err_o         (p_err),
      .mem_req_valid (mem_req_valid),
      .mem_req_ready (mem_req_ready),
      .mem_req_write (mem_req_write),
      .mem_req_addr  (mem_req_addr),
      .mem_req_wdata (mem_req_wdata),
      .mem_rsp_valid (mem_rsp_valid),
      .mem_rsp_err   (mem_rsp_err)
   );

   // R9: no memory traffic while the walker advertises idle
   a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !mem_req_valid);

   // R1: outputs come out of reset quiet
   a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> req_ready && !done);

endmodule

// File: tb/sim_entry_walker.sv
`timescale 1ns/1ps
module sim_entry_walker;

   localparam int unsigned ADDR_W = 52;
   localparam int unsigned IDX_W  = 20;
   localparam int unsigned LG_W   = 5;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cfg_two_level = 1'b0;
   logic [ADDR_W-1:0] cfg_base = '0;
   logic [LG_W-1:0]   cfg_page_lg2 = 5'd12;
   logic [LG_W-1:0]   cfg_entry_lg2 = 5'd3;
   logic              req_valid = 1'b0;
   logic              req_ready;
   logic              req_write = 1'b0;
   logic [IDX_W-1:0]  req_index = '0;
   logic [63:0]       req_wdata = '0;
   logic              done;
   logic [1:0]        rsp_status;
   logic [63:0]       rsp_rdata;
   logic              mem_req_valid;
   logic              mem_req_ready;
   logic              mem_req_write;
   logic [ADDR_W-1:0] mem_req_addr;
   logic [63:0]       mem_req_wdata;
   logic              mem_rsp_valid = 1'b0;
   logic              mem_rsp_err = 1'b0;
   logic [63:0]       mem_rsp_rdata = '0;

   always #2.5 clk = ~clk;

   entry_walker #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .LG_W(LG_W)) u0 (.*);

   // ---------------- memory model ----------------
   logic [63:0] mem_m [longint];
   int          n_txn, n_wr, n_lookup_wr;
   bit          fault_en = 1'b0;
   longint      fault_addr = 0;
   bit          bp_en = 1'b0;
   bit          tog = 1'b0;
   bit          cur_write = 1'b0;
   longint      key;
   bit          hit;

   assign mem_req_ready = !bp_en || tog;

   always @(posedge clk) begin
      tog <= ~tog;
      mem_rsp_valid <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
         key = longint'(mem_req_addr);
         hit = fault_en && (key == fault_addr);
         n_txn++;
         if (mem_req_write) n_wr++;
         if (mem_req_write && !cur_write) n_lookup_wr++;
         if (mem_req_write && !hit) mem_m[key] = mem_req_wdata;
         mem_rsp_valid <= 1'b1;
         mem_rsp_err   <= hit;
         mem_rsp_rdata <= (!mem_req_write && mem_m.exists(key)) ? mem_m[key] : 64'h0;
      end
   end

   // ---------------- bookkeeping ----------------
   int n_chk = 0;
   int n_err = 0;
   bit finished = 1'b0;

   task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
      end
   endtask

   function automatic longint exp_flat(longint base, longint idx, longint esz);
      return base + idx * esz;
   endfunction
   function automatic longint exp_l1(longint base, longint idx, longint psz);
      return base + (idx / (psz / 8)) * 8;
   endfunction
   function automatic longint exp_l2(logic [63:0] desc, longint idx, longint psz, longint esz);
      return longint'(desc & ((64'h1 << 51) - 64'h1)) + (idx % (psz / esz)) * esz;
   endfunction

   task automatic set_cfg(input bit two, input longint base, input int plg, input int elg);
      @(negedge clk);
      cfg_two_level = two;
      cfg_base      = ADDR_W'(base);
      cfg_page_lg2  = LG_W'(plg);
      cfg_entry_lg2 = LG_W'(elg);
   endtask

   logic [1:0]  r_st;
   logic [63:0] r_data;

   task automatic do_req(input bit wr, input int idx, input logic [63:0] wd);
      int cyc = 0;
      @(negedge clk);
      n_txn = 0; n_wr = 0; n_lookup_wr = 0;
      cur_write = wr;
      req_valid = 1'b1; req_write = wr; req_index = IDX_W'(idx); req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R9", "req_ready low during walk", 64'(req_ready), 64'h0);
      while (done !== 1'b1 && cyc < 1000) begin
         @(negedge clk);
         cyc++;
      end
      chk("R9", "done seen", 64'(done), 64'h1);
      r_st   = rsp_status;
      r_data = rsp_rdata;
      chk("R10", "lookup issued no write", 64'(n_lookup_wr), 64'h0);
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset;
      chk("R1", "req_ready", 64'(req_ready), 64'h1);
      chk("R1", "done", 64'(done), 64'h0);
      chk("R1", "mem_req_valid", 64'(mem_req_valid), 64'h0);
      chk("R1", "rsp_status", 64'(rsp_status), 64'h0);
      chk("R1", "rsp_rdata", rsp_rdata, 64'h0);
   endtask

   task automatic t_flat;
      longint a;
      set_cfg(1'b0, 64'h1000, 12, 3);
      a = exp_flat(64'h1000, 5, 8);
      mem_m[a] = 64'hA5A5_0000_1111_2222;
      do_req(1'b0, 5, 64'h0);
      chk("R2", "flat lookup status", 64'(r_st), 64'h0);
      chk("R2", "flat lookup data", r_data, 64'hA5A5_0000_1111_2222);
      chk("R2", "flat single txn", 64'(n_txn), 64'h1);
      set_cfg(1'b0, 64'h1000, 12, 4);
      a = exp_flat(64'h1000, 7, 16);
      do_req(1'b1, 7, 64'h0102_0304_0506_0708);
      chk("R7", "flat update status", 64'(r_st), 64'h0);
      chk("R7", "flat update stored", mem_m.exists(a) ? mem_m[a] : 64'hDEAD, 64'h0102_0304_0506_0708);
      chk("R2", "flat update one write", 64'(n_wr), 64'h1);
      chk("R2", "flat update txn", 64'(n_txn), 64'h1);
      chk("R8", "update returns no data", r_data, 64'h0);
   endtask

   task automatic t_two_level;
      logic [63:0] desc;
      longint l1, l2;
      set_cfg(1'b1, 64'h8000, 12, 3);
      desc = 64'h8000_0000_0004_0000;
      l1 = exp_l1(64'h8000, 1030, 4096);
      l2 = exp_l2(desc, 1030, 4096, 8);
      mem_m[l1] = desc;
      mem_m[l2] = 64'h1357_9BDF_2468_ACE0;
      do_req(1'b0, 1030, 64'h0);
      chk("R3", "walk lookup status", 64'(r_st), 64'h0);
      chk("R3", "walk lookup data", r_data, 64'h1357_9BDF_2468_ACE0);
      chk("R3", "walk txn count", 64'(n_txn), 64'h2);
      // second geometry, junk in descriptor bits 62..51
      set_cfg(1'b1, 64'h9000, 10, 4);
      desc = 64'hFFF8_0000_0002_0000;
      l1 = exp_l1(64'h9000, 300, 1024);
      l2 = exp_l2(desc, 300, 1024, 16);
      mem_m[l1] = desc;
      do_req(1'b1, 300, 64'hCAFE_F00D_0000_0042);
      chk("R3", "walk update status", 64'(r_st), 64'h0);
      chk("R3", "walk update at masked ptr", mem_m.exists(l2) ? mem_m[l2] : 64'hDEAD, 64'hCAFE_F00D_0000_0042);
      chk("R7", "walk update one write", 64'(n_wr), 64'h1);
   endtask

   task automatic t_unmapped;
      logic [63:0] desc;
      longint l1, l2;
      set_cfg(1'b1, 64'h8000, 12, 3);
      desc = 64'h0000_0000_0005_0000;
      l1 = exp_l1(64'h8000, 1600, 4096);
      l2 = exp_l2(desc, 1600, 4096, 8);
      mem_m[l1] = desc;
      mem_m[l2] = 64'h7777_7777_7777_7777;
      do_req(1'b0, 1600, 64'h0);
      chk("R4", "nomap lookup status", 64'(r_st), 64'h2);
      chk("R4", "nomap lookup data", r_data, 64'h0);
      chk("R4", "nomap lookup txn", 64'(n_txn), 64'h1);
      do_req(1'b1, 1600, 64'h1111_2222_3333_4444);
      chk("R5", "nomap update status", 64'(r_st), 64'h2);
      chk("R5", "nomap update no write", 64'(n_wr), 64'h0);
      chk("R5", "nomap update entry untouched", mem_m[l2], 64'h7777_7777_7777_7777);
   endtask

   task automatic t_faults;
      logic [63:0] desc;
      longint l1, l2;
      set_cfg(1'b1, 64'h8000, 12, 3);
      desc = 64'h8000_0000_0006_0000;
      l1 = exp_l1(64'h8000, 2100, 4096);
      l2 = exp_l2(desc, 2100, 4096, 8);
      mem_m[l1] = desc;
      mem_m[l2] = 64'h5555_AAAA_5555_AAAA;
      fault_en = 1'b1; fault_addr = l1;
      do_req(1'b0, 2100, 64'h0);
      chk("R6", "l1 fault lookup status", 64'(r_st), 64'h1);
      chk("R6", "l1 fault lookup data", r_data, 64'h0);
      chk("R6", "l1 fault lookup txn", 64'(n_txn), 64'h1);
      do_req(1'b1, 2100, 64'h9999_9999_9999_9999);
      chk("R6", "l1 fault update status", 64'(r_st), 64'h1);
      chk("R6", "l1 fault update no write", 64'(n_wr), 64'h0);
      fault_addr = l2;
      do_req(1'b0, 2100, 64'h0);
      chk("R8", "entry read fault status", 64'(r_st), 64'h1);
      chk("R8", "entry read fault data", r_data, 64'h0);
      chk("R8", "entry read fault txn", 64'(n_txn), 64'h2);
      set_cfg(1'b0, 64'h1000, 12, 3);
      fault_addr = exp_flat(64'h1000, 9, 8);
      do_req(1'b1, 9, 64'h4242_4242_4242_4242);
      chk("R7", "entry write fault status", 64'(r_st), 64'h1);
      chk("R7", "entry write fault issued write", 64'(n_wr), 64'h1);
      fault_en = 1'b0;
   endtask

   task automatic t_backpressure_hold;
      logic [63:0] desc;
      longint l1, l2;
      set_cfg(1'b1, 64'h20000, 11, 3);
      desc = 64'h8000_0000_0007_0000;
      l1 = exp_l1(64'h20000, 777, 2048);
      l2 = exp_l2(desc, 777, 2048, 8);
      mem_m[l1] = desc;
      mem_m[l2] = 64'h0F0E_0D0C_0B0A_0908;
      bp_en = 1'b1;
      do_req(1'b0, 777, 64'h0);
      bp_en = 1'b0;
      chk("R10", "stalled walk data", r_data, 64'h0F0E_0D0C_0B0A_0908);
      chk("R10", "stalled walk txn", 64'(n_txn), 64'h2);
      @(negedge clk);
      chk("R9", "done low after pulse", 64'(done), 64'h0);
      repeat (6) @(negedge clk);
      chk("R9", "status held", 64'(rsp_status), 64'h0);
      chk("R9", "data held", rsp_rdata, 64'h0F0E_0D0C_0B0A_0908);
      chk("R9", "ready after completion", 64'(req_ready), 64'h1);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_flat();
      t_two_level();
      t_unmapped();
      t_faults();
      t_backpressure_hold();
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog R9 act=%0d exp=%0d", 0, 1);
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

endmodule